// File: doc/BRIEF.md
# Bidirectional Parallel Port Register

This block is an eight-pin general-purpose parallel port. Software reaches it over a small synchronous register bus and sees three registers. The data latch holds the values that the pins drive. The direction register chooses, pin by pin, whether the pin drives or listens. The pullup register switches on a weak pullup for listening pins. On the pin side, each pin has an output enable, an output value, a pullup request and a sampled input. Incoming levels cross two flops before anything can read them.

When software reads the data register, each output bit returns its latched value and each input bit returns the synchronised pin level. The one exception is bit 2. It always returns its latched value, whatever its direction. A write stores all eight latch bits even where a pin is an input, so a value can be set up before the pin is turned to output. After reset every pin listens, with no pullup and nothing driven.

The bus decode sorts each access into one of four named selections: `SEL_DATA`, `SEL_DIR`, `SEL_PULL` and `SEL_NONE`. `SEL_NONE` covers any other offset. The read-data register moves to a new value only on a read strobe and holds it otherwise.

Top module: `pport_top`

## Requirements
- R1: After reset the data latch, the direction register and the pullup register are all zero. So `pin_oe`, `pin_pu` and `pin_out` are zero, and reads of offsets 0, 1 and 2 return zero.
- R2: A write to offset 0 stores all eight bits into the data latch, whatever the direction bits are. `pin_out` shows the latch one clock after the write. A latched value written while a pin is an input is driven as soon as that pin becomes an output.
- R3: A direction bit of 1 makes its pin an output (`pin_oe` bit = 1). A read of offset 0 then returns the latched value for that bit.
- R4: For an input bit other than bit 2, a read of offset 0 returns the pin level through a two-flop synchroniser. A level applied just before two back-to-back reads is not yet visible to them. The read that follows them sees it.
- R5: Bit 2 of a read of offset 0 always returns the latched value, for either direction setting and whatever level is on its pin.
- R6: Offset 1 is the 8-bit direction register, readable and writable (1 = output, 0 = input).
- R7: Offset 2 is the 8-bit pullup register, readable and writable. `pin_pu` equals pullup AND NOT direction, so a pullup is never requested on an output pin.
- R8: A read of offset 3 returns zero. A write to offset 3 changes none of the three registers.
- R9: `bus_rdata` is registered. It takes the selected value at the clock edge where `bus_rd` is high and holds that value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Latched output values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pullup request |

## Verification
The bench sets the latch of bit 2 against its pin level, in both directions. A design that treated bit 2 like the other bits would return the pin level and fail. It writes the latch while the pins are inputs and then turns them to outputs; a design that dropped writes to input bits would drive stale zeros. It reads straight after a pin changes, to expose a synchroniser that is missing or has the wrong depth. It sets pullups on pins that are outputs, to catch gating that was left out. It also writes and reads the unused offset, which catches a decode that aliases onto a real register.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e sel_of(input int unsigned off);
        if (off == 0)      return SEL_DATA;
        else if (off == 1) return SEL_DIR;
        else if (off == 2) return SEL_PULL;
        else               return SEL_NONE;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      pul_q
);
    reg_sel_e wsel;

    always_comb wsel = sel_of(32'(bus_addr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '0;
            pul_q <= '0;
        end else if (bus_wr) begin
            unique case (wsel)
                SEL_DATA: lat_q <= bus_wdata;
                SEL_DIR:  dir_q <= bus_wdata;
                SEL_PULL: pul_q <= bus_wdata;
                SEL_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
    import pport_pkg::*;
#(
    parameter int W         = 8,
    parameter int ADDR_W    = 2,
    parameter int FIXED_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      lat_q,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      pul_q,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      rdata_q
);
    localparam logic [W-1:0] FIX_MASK = W'(1) << FIXED_BIT;

    reg_sel_e     rsel;
    logic [W-1:0] take_lat;
    logic [W-1:0] data_view;
    logic [W-1:0] rd_next;

    always_comb begin
        rsel      = sel_of(32'(bus_addr));
        take_lat  = dir_q | FIX_MASK;
        data_view = (lat_q & take_lat) | (pin_sync & ~take_lat);
        unique case (rsel)
            SEL_DATA: rd_next = data_view;
            SEL_DIR:  rd_next = dir_q;
            SEL_PULL: rd_next = pul_q;
            SEL_NONE: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
    end
endmodule

// File: rtl/pport_top.sv
module pport_top #(
    parameter int W           = 8,
    parameter int ADDR_W      = 2,
    parameter int FIXED_BIT   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu
);
    logic [W-1:0] lat_q, dir_q, pul_q, pin_sync;

    pport_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q), .pul_q(pul_q)
    );

    pport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_sync)
    );

    pport_rdmux #(.W(W), .ADDR_W(ADDR_W), .FIXED_BIT(FIXED_BIT)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .lat_q(lat_q), .dir_q(dir_q), .pul_q(pul_q), .pin_sync(pin_sync),
        .rdata_q(bus_rdata)
    );

    assign pin_out = lat_q;
    assign pin_oe  = dir_q;
    assign pin_pu  = pul_q & ~dir_q;
endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
    parameter int W         = 8,
    parameter int ADDR_W    = 2,
    parameter int FIXED_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic              bus_rd,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_pu
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> pin_out == $past(bus_wdata));

    p_out_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |=>
            ((bus_rdata ^ $past(pin_out)) & $past(pin_oe)) == '0);

    p_fixed_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |=>
            bus_rdata[FIXED_BIT] == $past(pin_out[FIXED_BIT]));

    p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1)) |=> pin_oe == $past(bus_wdata));

    p_pull_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(3)) |=> bus_rdata == '0);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pport_top pport_chk #(.W(W), .ADDR_W(ADDR_W), .FIXED_BIT(FIXED_BIT)) u_chk (.*);

// File: tb/tb_pport_top.sv
module tb_pport_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int fails  = 0;
    logic rd_q = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] m_lat = '0, m_dir = '0, m_pul = '0;

    always #2 clk = ~clk;

    pport_top dut (.*);

    always @(posedge clk) rd_q <= bus_rd;

    // monitor: pops the expected item for each completed read
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    function automatic logic [7:0] data_exp(input logic [7:0] pins);
        logic [7:0] keep;
        keep = m_dir | 8'h04;
        return (m_lat & keep) | (pins & ~keep);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_lat = d;
        else if (a == 2'd1) m_dir = d;
        else if (a == 2'd2) m_pul = d;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(pin_oe,  8'h00, "R1 pin_oe");
        chk(pin_pu,  8'h00, "R1 pin_pu");
        chk(pin_out, 8'h00, "R1 pin_out");
        rd(2'd0, 8'h00, "R1 data");
        rd(2'd1, 8'h00, "R1 dir");
        rd(2'd2, 8'h00, "R1 pull");
        idle(1);

        // R2 latch written while all pins are inputs, then turned to outputs
        wr(2'd0, 8'h5A);
        chk(pin_out, 8'h5A, "R2 latch while input");
        chk(pin_oe,  8'h00, "R2 still input");
        wr(2'd1, 8'hF0);
        chk(pin_oe,  8'hF0, "R3 oe");
        chk(pin_out, 8'h5A, "R2 kept latch");
        rd(2'd1, 8'hF0, "R6 dir readback");

        // R3/R4 mixed directions
        pin_in = 8'h3C;
        idle(4);
        wr(2'd0, 8'hA5);
        rd(2'd0, data_exp(8'h3C), "R3 R4 mixed read");

        // R4 synchroniser latency
        pin_in = 8'hC3;
        rd(2'd0, data_exp(8'h3C), "R4 first read old");
        rd(2'd0, data_exp(8'h3C), "R4 second read old");
        rd(2'd0, data_exp(8'hC3), "R4 third read new");

        // R5 fixed bit, input direction, latch vs pin opposite
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h04);
        pin_in = 8'h00;
        idle(4);
        rd(2'd0, 8'h04, "R5 bit2 latch=1 pin=0");
        wr(2'd0, 8'h00);
        pin_in = 8'hFF;
        idle(4);
        rd(2'd0, 8'hFB, "R5 bit2 latch=0 pin=1");
        wr(2'd1, 8'h04);
        rd(2'd0, 8'hFB, "R5 bit2 as output");

        // R7 pullup gating
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'hFF);
        chk(pin_pu, 8'h0F, "R7 pullup gated");
        rd(2'd2, 8'hFF, "R7 pull readback");
        wr(2'd1, 8'h00);
        chk(pin_pu, 8'hFF, "R7 pullup all inputs");

        // R8 unused offset
        wr(2'd1, 8'h81);
        wr(2'd0, 8'h3E);
        wr(2'd3, 8'h55);
        rd(2'd3, 8'h00, "R8 unused reads zero");
        rd(2'd0, data_exp(pin_in), "R8 data unchanged");
        rd(2'd1, 8'h81, "R8 dir unchanged");
        rd(2'd2, 8'hFF, "R8 pull unchanged");
        chk(pin_out, 8'h3E, "R8 pin_out unchanged");

        // R9 hold through idle and writes
        wr(2'd2, 8'h12);
        idle(3);
        chk(bus_rdata, 8'hFF, "R9 rdata holds");

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule